// File: doc/BRIEF.md
# Serial ADC Host Frame Controller

This block is the host side of the serial link to a multi-channel 14-bit sampling converter. After a single-cycle start request it runs one complete operation cycle. It selects the converter and clocks out a 4-bit command word. A 12-bit configuration word may follow the command; when it is not wanted, zeros are sent in its place. In the same clocks the block collects the 14-bit result of the previous conversion that the converter returns on its data output. It then keeps the cycle open for the sampling window and the conversion, and only after that accepts a new request.

A frame can open in one of two ways. In the chip-select style, the select line falls and the frame-sync line stays high. In the frame-sync style, the select line falls first, and a frame-sync low pulse follows after a fixed set-up gap. The sampling window is 12 or 44 serial clocks long. With the external conversion clock, the serial clock keeps running for 72 more periods. With the internal conversion clock, the serial clock stops and the block counts out a fixed number of system clocks. The mode, command and configuration are captured when the request is accepted, so the user side may change them during a frame.

Top module: `adc_frame_ctrl`

## Requirements
- R1: During reset and whenever no frame is in progress, `adc_cs_n` and `adc_fs` are high, `adc_sclk`, `adc_sdi`, `busy_o` and `result_valid_o` are low.
- R2: With `fs_mode_i`=0, `adc_cs_n` falls on the clock edge that accepts `start_i`, `adc_fs` stays high for the whole frame, and the first SCLK rising edge comes SCLK_HALF system clocks later.
- R3: With `fs_mode_i`=1, `adc_cs_n` falls on the accepting edge, `adc_fs` falls CS_FS_GAP clocks later and returns high on the first SCLK falling edge, the first SCLK rise comes SCLK_HALF clocks after `adc_fs` falls, and `adc_fs` is low only while `adc_cs_n` is low.
- R4: SCLK idles low and, while running, stays high for SCLK_HALF and low for SCLK_HALF system clocks.
- R5: SDI carries 16 bits MSB first: `cmd_i[3]` first, then `cfg_i[11]` down to `cfg_i[0]` when `cfg_en_i`=1, or 12 zeros when `cfg_en_i`=0. The first bit is on the line before the first SCLK rise. SDI changes only together with an SCLK fall, and it stays low after the 16th bit until the frame ends.
- R6: `adc_sdo` is sampled on each of the first 14 SCLK falling edges. The first bit received becomes `result_o[13]`, and all later SDO bits in the frame are ignored.
- R7: `result_valid_o` is high for exactly one system clock per frame. It rises on the edge of the 14th SCLK fall, which is 2·SCLK_HALF·14 clocks after the first SCLK starts counting.
- R8: The sampling part of the frame has 16 SCLK periods when `long_smp_i`=0 and 48 when `long_smp_i`=1.
- R9: With `ext_clk_i`=1, 72 further SCLK periods follow the sampling part, with SDI low and SDO ignored.
- R10: With `ext_clk_i`=0, SCLK stays low after the sampling part, and the frame ends INT_CONV_WAIT system clocks after the last SCLK fall.
- R11: `busy_o` is high for gap + 2·SCLK_HALF·L + conv system clocks. Here gap is CS_FS_GAP in frame-sync style and 0 otherwise, L is 16 or 48, and conv is 2·SCLK_HALF·72 or INT_CONV_WAIT.
- R12: A `start_i` that arrives during a frame is ignored, and changes to `cmd_i`, `cfg_i`, `cfg_en_i`, `fs_mode_i`, `long_smp_i` and `ext_clk_i` during a frame have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request to run one operation cycle |
| cmd_i | input | 4 | Command word sent first |
| cfg_i | input | 12 | Configuration word |
| cfg_en_i | input | 1 | Send the configuration word (1) or zeros (0) |
| fs_mode_i | input | 1 | 0: chip-select starts the frame, 1: frame-sync pulse starts it |
| long_smp_i | input | 1 | 0: 12-clock sampling window, 1: 44-clock window |
| ext_clk_i | input | 1 | 0: internal conversion clock, 1: SCLK-driven conversion |
| busy_o | output | 1 | Operation cycle in progress |
| result_o | output | 14 | Previous conversion result |
| result_valid_o | output | 1 | One-clock pulse when result_o is complete |
| adc_cs_n | output | 1 | Converter select, active low |
| adc_fs | output | 1 | Frame sync, active-low pulse |
| adc_sclk | output | 1 | Serial clock |
| adc_sdi | output | 1 | Serial data to the converter |
| adc_sdo | input | 1 | Serial data from the converter |

## Verification
The hardest case to reach from the ports is a frame that has to ignore everything that changes while it runs. That covers a second start request, flipped mode inputs, and SDO bits after the 14th that still toggle. Each has to leave the timing and the captured word unchanged. To get there, the bench acts as the converter: it drives SDO from a 16-bit word on each SCLK rise and drives ones once that word is used up. In selected table rows it raises `start_i` and inverts every mode and command input in the middle of the frame. It then checks that the busy length, SCLK count, SDI bits and result all still match the settings captured at the start.

// File: rtl/afc_pkg.sv
package afc_pkg;
    localparam int unsigned AFC_CMD_W     = 4;
    localparam int unsigned AFC_CFG_W     = 12;
    localparam int unsigned AFC_RES_W     = 14;
    localparam int unsigned AFC_SHORT_SMP = 12;
    localparam int unsigned AFC_LONG_SMP  = 44;
    localparam int unsigned AFC_EXT_CONV  = 72;

    typedef enum logic [2:0] {
        AFC_IDLE,
        AFC_GAP,
        AFC_SHIFT,
        AFC_CONV_EXT,
        AFC_CONV_INT
    } afc_state_e;
endpackage

// File: rtl/afc_sclk_gen.sv
module afc_sclk_gen #(
    parameter int unsigned HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic sclk_o,
    output logic fall_o
);
    logic tick;
    logic sclk_d, sclk_q;

    generate
        if (HALF == 1) begin : g_nodiv
            assign tick = run;
        end else begin : g_div
            localparam int unsigned W = $clog2(HALF);
            logic [W-1:0] cnt_d, cnt_q;

            always_comb begin
                cnt_d = cnt_q;
                if (!run || cnt_q == W'(HALF - 1)) cnt_d = '0;
                else                               cnt_d = cnt_q + 1'b1;
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) cnt_q <= '0;
                else        cnt_q <= cnt_d;
            end

            assign tick = run && (cnt_q == W'(HALF - 1));
        end
    endgenerate

    always_comb begin
        sclk_d = 1'b0;
        if (run) sclk_d = tick ? ~sclk_q : sclk_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sclk_q <= 1'b0;
        else        sclk_q <= sclk_d;
    end

    assign sclk_o = sclk_q;
    assign fall_o = tick && sclk_q;
endmodule

// File: rtl/afc_rx_capture.sv
module afc_rx_capture #(
    parameter int unsigned RES_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             sample,
    input  logic             sdo,
    output logic [RES_W-1:0] data_o,
    output logic             valid_o
);
    localparam int unsigned CW = $clog2(RES_W + 1);

    typedef struct packed {
        logic [RES_W-1:0] data;
        logic [CW-1:0]    cnt;
        logic             valid;
    } rx_t;

    rx_t r_d, r_q;

    always_comb begin
        r_d       = r_q;
        r_d.valid = 1'b0;
        if (clr) begin
            r_d.cnt = '0;
        end else if (sample && r_q.cnt != CW'(RES_W)) begin
            r_d.data = {r_q.data[RES_W-2:0], sdo};
            r_d.cnt  = r_q.cnt + 1'b1;
            if (r_q.cnt == CW'(RES_W - 1)) r_d.valid = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign data_o  = r_q.data;
    assign valid_o = r_q.valid;
endmodule

// File: rtl/adc_frame_ctrl.sv
module adc_frame_ctrl
    import afc_pkg::*;
#(
    parameter int unsigned SCLK_HALF     = 2,
    parameter int unsigned CS_FS_GAP     = 3,
    parameter int unsigned INT_CONV_WAIT = 50
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic [AFC_CMD_W-1:0] cmd_i,
    input  logic [AFC_CFG_W-1:0] cfg_i,
    input  logic                 cfg_en_i,
    input  logic                 fs_mode_i,
    input  logic                 long_smp_i,
    input  logic                 ext_clk_i,
    output logic                 busy_o,
    output logic [AFC_RES_W-1:0] result_o,
    output logic                 result_valid_o,
    output logic                 adc_cs_n,
    output logic                 adc_fs,
    output logic                 adc_sclk,
    output logic                 adc_sdi,
    input  logic                 adc_sdo
);
    localparam int unsigned FRAME_W   = AFC_CMD_W + AFC_CFG_W;
    localparam int unsigned SHORT_LEN = AFC_CMD_W + AFC_SHORT_SMP;
    localparam int unsigned LONG_LEN  = AFC_CMD_W + AFC_LONG_SMP;
    localparam int unsigned BIT_MAX   = (LONG_LEN > AFC_EXT_CONV) ? LONG_LEN : AFC_EXT_CONV;
    localparam int unsigned BIT_W     = $clog2(BIT_MAX + 1);
    localparam int unsigned WAIT_MAX  = (INT_CONV_WAIT > CS_FS_GAP) ? INT_CONV_WAIT : CS_FS_GAP;
    localparam int unsigned WAIT_W    = $clog2(WAIT_MAX + 1);

    typedef struct packed {
        afc_state_e         st;
        logic [BIT_W-1:0]   bits;
        logic [WAIT_W-1:0]  wt;
        logic [FRAME_W-1:0] tx;
        logic               cs_n;
        logic               fs;
        logic               lng;
        logic               ext;
    } ctrl_t;

    localparam ctrl_t CTRL_RST = '{
        st: AFC_IDLE, bits: '0, wt: '0, tx: '0,
        cs_n: 1'b1, fs: 1'b1, lng: 1'b0, ext: 1'b0
    };

    ctrl_t            r_d, r_q;
    logic             sclk_run;
    logic             sclk_fall;
    logic             rx_clr;
    logic             rx_sample;
    logic [BIT_W-1:0] frame_last;

    assign sclk_run   = (r_q.st == AFC_SHIFT) || (r_q.st == AFC_CONV_EXT);
    assign frame_last = r_q.lng ? BIT_W'(LONG_LEN - 1) : BIT_W'(SHORT_LEN - 1);
    assign rx_sample  = sclk_fall && (r_q.st == AFC_SHIFT);

    afc_sclk_gen #(.HALF(SCLK_HALF)) u_sclk (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (sclk_run),
        .sclk_o (adc_sclk),
        .fall_o (sclk_fall)
    );

    afc_rx_capture #(.RES_W(AFC_RES_W)) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (rx_clr),
        .sample  (rx_sample),
        .sdo     (adc_sdo),
        .data_o  (result_o),
        .valid_o (result_valid_o)
    );

    always_comb begin
        r_d    = r_q;
        rx_clr = 1'b0;
        unique case (r_q.st)
            AFC_IDLE: begin
                if (start_i) begin
                    r_d.tx   = {cmd_i, (cfg_en_i ? cfg_i : {AFC_CFG_W{1'b0}})};
                    r_d.cs_n = 1'b0;
                    r_d.fs   = 1'b1;
                    r_d.bits = '0;
                    r_d.wt   = '0;
                    r_d.lng  = long_smp_i;
                    r_d.ext  = ext_clk_i;
                    r_d.st   = fs_mode_i ? AFC_GAP : AFC_SHIFT;
                    rx_clr   = 1'b1;
                end
            end
            AFC_GAP: begin
                if (r_q.wt == WAIT_W'(CS_FS_GAP - 1)) begin
                    r_d.wt = '0;
                    r_d.fs = 1'b0;
                    r_d.st = AFC_SHIFT;
                end else begin
                    r_d.wt = r_q.wt + 1'b1;
                end
            end
            AFC_SHIFT: begin
                if (sclk_fall) begin
                    r_d.tx = {r_q.tx[FRAME_W-2:0], 1'b0};
                    r_d.fs = 1'b1;
                    if (r_q.bits == frame_last) begin
                        r_d.bits = '0;
                        r_d.st   = r_q.ext ? AFC_CONV_EXT : AFC_CONV_INT;
                    end else begin
                        r_d.bits = r_q.bits + 1'b1;
                    end
                end
            end
            AFC_CONV_EXT: begin
                if (sclk_fall) begin
                    if (r_q.bits == BIT_W'(AFC_EXT_CONV - 1)) begin
                        r_d.bits = '0;
                        r_d.cs_n = 1'b1;
                        r_d.st   = AFC_IDLE;
                    end else begin
                        r_d.bits = r_q.bits + 1'b1;
                    end
                end
            end
            AFC_CONV_INT: begin
                if (r_q.wt == WAIT_W'(INT_CONV_WAIT - 1)) begin
                    r_d.wt   = '0;
                    r_d.cs_n = 1'b1;
                    r_d.st   = AFC_IDLE;
                end else begin
                    r_d.wt = r_q.wt + 1'b1;
                end
            end
            default: r_d = CTRL_RST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= CTRL_RST;
        else        r_q <= r_d;
    end

    assign adc_cs_n = r_q.cs_n;
    assign adc_fs   = r_q.fs;
    assign adc_sdi  = r_q.tx[FRAME_W-1];
    assign busy_o   = ~r_q.cs_n;
endmodule

// File: rtl/afc_frame_chk.sv
module afc_frame_chk (
    input logic clk,
    input logic rst_n,
    input logic busy_o,
    input logic result_valid_o,
    input logic adc_cs_n,
    input logic adc_fs,
    input logic adc_sclk,
    input logic adc_sdi
);
    // R1: link quiet outside a frame
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!adc_sclk && adc_cs_n && adc_fs));

    // R3: frame sync only asserted under an active select
    a_r3_fs_under_cs: assert property (@(posedge clk) disable iff (!rst_n)
        !adc_fs |-> !adc_cs_n);

    // R5: data to the converter is steady across each SCLK rise
    a_r5_sdi_stable_at_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(adc_sclk) |-> $stable(adc_sdi));

    // R7: result strobe lasts a single clock
    a_r7_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid_o |=> !result_valid_o);

    // R7: result strobe only inside a frame
    a_r7_valid_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid_o |-> (busy_o && !adc_cs_n));

    // R4: SCLK never runs while the select is high
    a_r4_sclk_under_cs: assert property (@(posedge clk) disable iff (!rst_n)
        adc_sclk |-> !adc_cs_n);
endmodule

bind adc_frame_ctrl afc_frame_chk u_afc_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .busy_o         (busy_o),
    .result_valid_o (result_valid_o),
    .adc_cs_n       (adc_cs_n),
    .adc_fs         (adc_fs),
    .adc_sclk       (adc_sclk),
    .adc_sdi        (adc_sdi)
);

// File: tb/test_adc_frame_ctrl.sv
`timescale 1ns/1ps
module test_adc_frame_ctrl;
    localparam int HALF = 2;
    localparam int GAP  = 3;
    localparam int INTW = 50;

    typedef struct packed {
        logic        fsm;
        logic        lng;
        logic        ext;
        logic        cfg_en;
        logic        poke;
        logic [3:0]  cmd;
        logic [11:0] cfg;
        logic [15:0] word;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 4'hA, 12'h5A3, 16'hB5C7},
        '{1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'h3, 12'hFFF, 16'h3FFD},
        '{1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 4'hF, 12'h8E1, 16'h8001},
        '{1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 4'h1, 12'h7FF, 16'h4002},
        '{1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 4'h8, 12'h123, 16'hFFFF},
        '{1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 4'h6, 12'hC3C, 16'h0000}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [3:0]  cmd_i = '0;
    logic [11:0] cfg_i = '0;
    logic        cfg_en_i = 1'b0;
    logic        fs_mode_i = 1'b0;
    logic        long_smp_i = 1'b0;
    logic        ext_clk_i = 1'b0;
    logic        busy_o;
    logic [13:0] result_o;
    logic        result_valid_o;
    logic        adc_cs_n, adc_fs, adc_sclk, adc_sdi;
    logic        adc_sdo = 1'b0;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    adc_frame_ctrl #(
        .SCLK_HALF(HALF), .CS_FS_GAP(GAP), .INT_CONV_WAIT(INTW)
    ) i_adc_frame_ctrl (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .cmd_i(cmd_i), .cfg_i(cfg_i),
        .cfg_en_i(cfg_en_i), .fs_mode_i(fs_mode_i), .long_smp_i(long_smp_i),
        .ext_clk_i(ext_clk_i), .busy_o(busy_o), .result_o(result_o),
        .result_valid_o(result_valid_o), .adc_cs_n(adc_cs_n), .adc_fs(adc_fs),
        .adc_sclk(adc_sclk), .adc_sdi(adc_sdi), .adc_sdo(adc_sdo)
    );

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic chk_idle(input string req);
        chk(req, "idle pins {cs_n,fs,sclk,sdi,busy,valid}",
            {adc_cs_n, adc_fs, adc_sclk, adc_sdi, busy_o, result_valid_o}, 6'b110000);
    endtask

    task automatic run_frame(input vec_t v);
        int n = 0, busy_cnt = 0, rises = 0, first_rise = 0;
        int cs_fall = 0, fs_fall = 0, fs_rise = 0, valid_cnt = 0, valid_idx = 0;
        bit fs_low_seen = 0, late_one = 0, sdi_bad = 0;
        logic [15:0] sdi_cap = '0;
        logic prev_sclk, prev_sdi;
        int gap   = v.fsm ? GAP : 0;
        int len   = v.lng ? 48 : 16;
        int conv  = v.ext ? 2 * HALF * 72 : INTW;
        string sm = v.fsm ? "R3" : "R2";

        @(negedge clk);
        cmd_i = v.cmd; cfg_i = v.cfg; cfg_en_i = v.cfg_en;
        fs_mode_i = v.fsm; long_smp_i = v.lng; ext_clk_i = v.ext;
        adc_sdo = 1'b0;
        start_i = 1'b1;
        prev_sclk = adc_sclk; prev_sdi = adc_sdi;
        @(negedge clk);
        start_i = 1'b0;
        while (n < 3000) begin
            n++;
            if (busy_o) busy_cnt++;
            if (!adc_cs_n && cs_fall == 0) cs_fall = n;
            if (!adc_fs) begin
                fs_low_seen = 1;
                if (fs_fall == 0) fs_fall = n;
            end else if (fs_fall != 0 && fs_rise == 0) fs_rise = n;
            if (n > 1 && adc_sdi != prev_sdi && !(prev_sclk && !adc_sclk)) sdi_bad = 1;
            if (adc_sclk && !prev_sclk) begin
                if (rises == 0) first_rise = n;
                if (rises < 16) sdi_cap[15 - rises] = adc_sdi;
                else if (adc_sdi) late_one = 1;
                adc_sdo = (rises < 16) ? v.word[15 - rises] : 1'b1;
                rises++;
            end
            if (result_valid_o) begin
                valid_cnt++;
                if (valid_idx == 0) valid_idx = n;
            end
            if (v.poke && n == 40) begin
                start_i = 1'b1;
                cmd_i = ~v.cmd; cfg_i = ~v.cfg; cfg_en_i = ~v.cfg_en;
                fs_mode_i = ~v.fsm; long_smp_i = ~v.lng; ext_clk_i = ~v.ext;
            end else begin
                start_i = 1'b0;
            end
            prev_sclk = adc_sclk; prev_sdi = adc_sdi;
            if (!busy_o && n > 1) break;
            @(negedge clk);
        end
        start_i = 1'b0;

        chk(sm, "cs_n fall index", cs_fall, 1);
        if (v.fsm) begin
            chk("R3", "fs fall index", fs_fall, GAP + 1);
            chk("R3", "fs return index", fs_rise, GAP + 2 * HALF + 1);
        end else begin
            chk("R2", "fs low seen", fs_low_seen, 0);
        end
        chk("R4", "first SCLK rise index", first_rise, gap + HALF + 1);
        chk(v.ext ? "R9" : "R8", "SCLK rise count", rises, len + (v.ext ? 72 : 0));
        chk("R5", "SDI word", sdi_cap, {v.cmd, (v.cfg_en ? v.cfg : 12'h000)});
        chk("R5", "SDI high after 16th bit", late_one, 0);
        chk("R5", "SDI change off SCLK fall", sdi_bad, 0);
        chk("R6", "result", result_o, v.word[15:2]);
        chk("R7", "valid pulse count", valid_cnt, 1);
        chk("R7", "valid index", valid_idx, gap + 2 * HALF * 14 + 1);
        chk("R11", "busy length", busy_cnt, gap + 2 * HALF * len + conv);
        if (!v.ext) chk("R10", "internal wait", busy_cnt - gap - 2 * HALF * len, INTW);

        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            chk(v.poke ? "R12" : "R1", "pins after frame", 
                {adc_cs_n, adc_fs, adc_sclk, busy_o}, 4'b1100);
        end
    endtask

    initial begin
        for (int c = 0; c < 150000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog actual=expired expected=finished");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk_idle("R1");
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk_idle("R1");

        for (int i = 0; i < NV; i++) run_frame(VECS[i]);

        // R1: reset in the middle of a frame returns the link to idle
        @(negedge clk);
        cmd_i = 4'h5; fs_mode_i = 1'b0; long_smp_i = 1'b1; ext_clk_i = 1'b1;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (30) @(negedge clk);
        chk("R1", "busy before reset", busy_o, 1);
        rst_n = 1'b0;
        @(negedge clk);
        chk_idle("R1");
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk_idle("R1");

        // R2: a frame after the reset still runs normally
        run_frame('{1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 4'h9, 12'hA5A, 16'h5556});

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule